// File: doc/BRIEF.md
# Key-Protected Reset Control Register Block

This block is a small register file on a plain 32-bit word bus. It holds three software-visible registers: a reset-control word, a reset-status word and a watchdog word. Every write must carry a fixed 8-bit key in the top byte of the write data. A write with any other key is discarded. When the key matches, the block clears the key byte and stores the remaining 24 bits, so the key is never visible on a read.

Writing the trigger bit into the reset-control word asks the system to go down. The block then inspects a 12-bit code in the reset-status word, taking the value that word held before the write. A halt code produces a one-cycle power-off request. Any other code produces a one-cycle system-reset request.

Reads are registered, with one cycle of latency. Offsets that are not mapped read as zero and ignore writes.

Top module: `pm_reset_regs`

## Requirements
- R1: A write is accepted only when wrData[31:24] equals 0x5A. Any other key leaves all three registers unchanged and raises no request.
- R2: An accepted write stores wrData with bits 31:24 forced to zero, so a later read shows 0x00 in the top byte.
- R3: The word address selects the register: word index 7 (byte offset 0x1C) is reset-control, index 8 (0x20) is reset-status, index 9 (0x24) is watchdog. A read request loads rdData at the next clock edge.
- R4: A read of any other index in the 128-word window returns zero. A write to such an index, even with a valid key, changes no register and raises no request.
- R5: A synchronous reset loads reset-control with 0x00000102, reset-status with 0x00001000 and watchdog with 0x00000000, and clears both request outputs.
- R6: An accepted reset-control write with bit 5 set raises exactly one request, in the cycle after the write and for one cycle only. Without bit 5 set, no request is raised.
- R7: The request is powerOffReq when bits 11:0 of the reset-status register equal 0x555 at the time of the write, and sysResetReq otherwise. The two requests are never high together.
- R8: The reset-status and watchdog registers hold any accepted 24-bit payload unchanged. A watchdog write starts no timing activity and raises no request.
- R9: A read and an accepted write to the same register in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write request for this cycle |
| rdEn | input | 1 | Read request for this cycle |
| addr | input | 7 | Word address within the 0x200-byte window |
| wrData | input | 32 | Write data; top byte carries the key |
| rdData | output | 32 | Registered read data |
| powerOffReq | output | 1 | One-cycle power-off request |
| sysResetReq | output | 1 | One-cycle system-reset request |

## Verification
Two things can land in the same cycle: a read and an accepted write to the same register, and a reset trigger together with the status-code lookup that decides between halt and reboot.

The first case is provoked by issuing a read and a keyed write to one index in a single cycle. The returned word must be the old contents, and a read in the following cycle must show the new contents.

The second case is provoked by loading halt, near-halt and non-halt codes into the status register and then writing the trigger. Only the status value held before the trigger write may select which request pulses. The other request must stay low throughout.

// File: rtl/pm_reg_pkg.sv
package pm_reg_pkg;
  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic wrWdog;
    logic reqHalt;
    logic reqReboot;
  } pmStrobeT;
endpackage

// File: rtl/pm_reg_ctrl.sv
module pm_reg_ctrl
  import pm_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'h5A,
  parameter int CTRL_IDX = 7,
  parameter int STAT_IDX = 8,
  parameter int WDOG_IDX = 9,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] HALT_CODE = 12'h555
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic              trigBit,
  input  logic [CODE_W-1:0] statCode,
  output pmStrobeT          strobe,
  output logic              powerOffReq,
  output logic              sysResetReq
);
  logic accepted;
  logic haltCode;

  assign accepted = wrEn && (wrKey == KEY);
  assign haltCode = (statCode == HALT_CODE);

  always_comb begin
    strobe = '0;
    strobe.wrCtrl = accepted && (addr == ADDR_W'(CTRL_IDX));
    strobe.wrStat = accepted && (addr == ADDR_W'(STAT_IDX));
    strobe.wrWdog = accepted && (addr == ADDR_W'(WDOG_IDX));
    strobe.reqHalt = strobe.wrCtrl && trigBit && haltCode;
    strobe.reqReboot = strobe.wrCtrl && trigBit && !haltCode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      powerOffReq <= 1'b0;
      sysResetReq <= 1'b0;
    end else begin
      powerOffReq <= strobe.reqHalt;
      sysResetReq <= strobe.reqReboot;
    end
  end
endmodule

// File: rtl/pm_reg_data.sv
module pm_reg_data
  import pm_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int KEY_W = 8,
  parameter int CTRL_IDX = 7,
  parameter int STAT_IDX = 8,
  parameter int WDOG_IDX = 9,
  parameter logic [DATA_W-1:0] CTRL_RST = 32'h0000_0102,
  parameter logic [DATA_W-1:0] STAT_RST = 32'h0000_1000,
  parameter logic [DATA_W-1:0] WDOG_RST = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  pmStrobeT          strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] statQ,
  output logic [DATA_W-1:0] wdogQ
);
  localparam int PAY_W = DATA_W - KEY_W;
  localparam int NREG = 3;

  logic [DATA_W-1:0] stripped;
  logic [NREG-1:0]   wrVec;
  logic [DATA_W-1:0] regQ [NREG];

  assign stripped = {{KEY_W{1'b0}}, wrData[PAY_W-1:0]};
  assign wrVec = {strobe.wrWdog, strobe.wrStat, strobe.wrCtrl};

  function automatic logic [DATA_W-1:0] rstVal(input int idx);
    case (idx)
      0: return CTRL_RST;
      1: return STAT_RST;
      default: return WDOG_RST;
    endcase
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst) regQ[g] <= rstVal(g);
      else if (wrVec[g]) regQ[g] <= stripped;
    end
  end

  assign ctrlQ = regQ[0];
  assign statQ = regQ[1];
  assign wdogQ = regQ[2];

  logic [DATA_W-1:0] rdSel;
  always_comb begin
    if (addr == ADDR_W'(CTRL_IDX)) rdSel = regQ[0];
    else if (addr == ADDR_W'(STAT_IDX)) rdSel = regQ[1];
    else if (addr == ADDR_W'(WDOG_IDX)) rdSel = regQ[2];
    else rdSel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (rdEn) rdData <= rdSel;
  end
endmodule

// File: rtl/pm_reset_regs.sv
module pm_reset_regs
  import pm_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'h5A,
  parameter int CTRL_IDX = 7,
  parameter int STAT_IDX = 8,
  parameter int WDOG_IDX = 9,
  parameter int TRIG_BIT = 5,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] HALT_CODE = 12'h555
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              powerOffReq,
  output logic              sysResetReq
);
  pmStrobeT strobe;
  logic [DATA_W-1:0] ctrlQ, statQ, wdogQ;

  pm_reg_ctrl #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY(KEY),
    .CTRL_IDX(CTRL_IDX), .STAT_IDX(STAT_IDX), .WDOG_IDX(WDOG_IDX),
    .CODE_W(CODE_W), .HALT_CODE(HALT_CODE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
    .wrKey(wrData[DATA_W-1 -: KEY_W]),
    .trigBit(wrData[TRIG_BIT]),
    .statCode(statQ[CODE_W-1:0]),
    .strobe(strobe),
    .powerOffReq(powerOffReq), .sysResetReq(sysResetReq)
  );

  pm_reg_data #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .CTRL_IDX(CTRL_IDX), .STAT_IDX(STAT_IDX), .WDOG_IDX(WDOG_IDX)
  ) u_data (
    .clk(clk), .rst(rst), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .strobe(strobe), .rdData(rdData),
    .ctrlQ(ctrlQ), .statQ(statQ), .wdogQ(wdogQ)
  );
endmodule

// File: rtl/pm_reset_regs_chk.sv
module pm_reset_regs_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int CTRL_IDX = 7,
  parameter int STAT_IDX = 8,
  parameter int WDOG_IDX = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              powerOffReq,
  input logic              sysResetReq,
  input logic [DATA_W-1:0] ctrlQ,
  input logic [DATA_W-1:0] statQ,
  input logic [DATA_W-1:0] wdogQ
);
  logic badKey, okKey, mapped;
  assign badKey = wrEn && (wrData[31:24] != 8'h5A);
  assign okKey = wrEn && (wrData[31:24] == 8'h5A);
  assign mapped = (addr == ADDR_W'(CTRL_IDX)) || (addr == ADDR_W'(STAT_IDX)) ||
                  (addr == ADDR_W'(WDOG_IDX));

  assert_bad_key_R1: assert property (@(posedge clk) disable iff (rst)
    badKey |=> ($stable(ctrlQ) && $stable(statQ) && $stable(wdogQ) &&
                !powerOffReq && !sysResetReq));

  assert_key_stripped_R2: assert property (@(posedge clk) disable iff (rst)
    (okKey && addr == ADDR_W'(CTRL_IDX)) |=>
      (ctrlQ == {8'h00, $past(wrData[23:0])}));

  assert_unmapped_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !mapped) |=> (rdData == '0));

  assert_reset_values_R5: assert property (@(posedge clk)
    rst |=> (ctrlQ == 32'h102 && statQ == 32'h1000 && wdogQ == 32'h0 &&
             !powerOffReq && !sysResetReq));

  assert_halt_pick_R7: assert property (@(posedge clk) disable iff (rst)
    (okKey && addr == ADDR_W'(CTRL_IDX) && wrData[5] && statQ[11:0] == 12'h555)
      |=> powerOffReq);

  assert_never_both_R7: assert property (@(posedge clk) disable iff (rst)
    !(powerOffReq && sysResetReq));

  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (powerOffReq || sysResetReq) |=> !(powerOffReq || sysResetReq));
endmodule

bind pm_reset_regs pm_reset_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CTRL_IDX(CTRL_IDX), .STAT_IDX(STAT_IDX), .WDOG_IDX(WDOG_IDX)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .powerOffReq(powerOffReq),
  .sysResetReq(sysResetReq), .ctrlQ(ctrlQ), .statQ(statQ), .wdogQ(wdogQ)
);

// File: tb/test_pm_reset_regs.sv
module test_pm_reset_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic powerOffReq, sysResetReq;

  int checks = 0;
  int errors = 0;
  logic [31:0] mCtrl, mStat, mWdog;

  always #2.5 clk = ~clk;

  pm_reset_regs i_pm_reset_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .powerOffReq(powerOffReq), .sysResetReq(sysResetReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [6:0] a);
    case (a)
      7'd7: return mCtrl;
      7'd8: return mStat;
      7'd9: return mWdog;
      default: return 32'h0;
    endcase
  endfunction

  // one write cycle; returns request outputs seen in the cycle after it
  task automatic doWrite(input logic [6:0] a, input logic [31:0] d,
                         output logic po, output logic sr);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    po = powerOffReq; sr = sysResetReq;
    if (d[31:24] == 8'h5A) begin
      case (a)
        7'd7: mCtrl = {8'h00, d[23:0]};
        7'd8: mStat = {8'h00, d[23:0]};
        7'd9: mWdog = {8'h00, d[23:0]};
        default: ;
      endcase
    end
  endtask

  task automatic doRead(input logic [6:0] a, output logic [31:0] q);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    q = rdData;
  endtask

  task automatic trigCase(input string req, input logic [31:0] statWord,
                          input logic [31:0] ctrlWord, input logic expPo,
                          input logic expSr);
    logic po, sr;
    logic [31:0] q;
    doWrite(7'd8, statWord, po, sr);
    doWrite(7'd7, ctrlWord, po, sr);
    check({req, " pulse powerOff"}, {31'b0, po}, {31'b0, expPo});
    check({req, " pulse sysReset"}, {31'b0, sr}, {31'b0, expSr});
    @(negedge clk);
    check({req, " R6 pulse ends"}, {30'b0, powerOffReq, sysResetReq}, 32'h0);
    doRead(7'd7, q);
    check({req, " ctrl readback"}, q, mCtrl);
  endtask

  initial begin
    logic po, sr;
    logic [31:0] q;
    mCtrl = 32'h102; mStat = 32'h1000; mWdog = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R5 requests low", {30'b0, powerOffReq, sysResetReq}, 32'h0);

    // R3 R4 R5: sweep the whole window after reset
    for (int a = 0; a < 128; a++) begin
      doRead(7'(a), q);
      check("R3/R4/R5 reset read", q, model(7'(a)));
    end

    // R1 R2 R8: sweep every key value on the watchdog register
    for (int k = 0; k < 256; k++) begin
      doWrite(7'd9, {8'(k), 8'(k), 8'(~k), 8'(k ^ 8'h3C)}, po, sr);
      check("R1/R8 no request", {30'b0, po, sr}, 32'h0);
      doRead(7'd9, q);
      check("R1/R2 wdog value", q, mWdog);
    end

    // R8: status register stores payloads; R1 bad key on status and ctrl
    doWrite(7'd8, 32'h5AABCDEF, po, sr);
    doRead(7'd8, q);
    check("R8 status store", q, 32'h00ABCDEF);
    doWrite(7'd8, 32'hA5123456, po, sr);
    doWrite(7'd7, 32'h5B000020, po, sr);
    check("R1 bad key no request", {30'b0, po, sr}, 32'h0);
    doRead(7'd8, q);
    check("R1 status kept", q, 32'h00ABCDEF);
    doRead(7'd7, q);
    check("R1 ctrl kept", q, 32'h102);

    // R4: valid key on every unmapped index changes nothing
    for (int a = 0; a < 128; a++) begin
      if (a < 7 || a > 9) begin
        doWrite(7'(a), 32'h5AFFFFFF, po, sr);
        if (po || sr) check("R4 unmapped no request", {30'b0, po, sr}, 32'h0);
      end
    end
    for (int a = 7; a <= 9; a++) begin
      doRead(7'(a), q);
      check("R4 mapped regs untouched", q, model(7'(a)));
    end

    // R6 R7: trigger decisions
    trigCase("R7 halt code", 32'h5A000555, 32'h5A000020, 1'b1, 1'b0);
    trigCase("R7 halt code upper bits", 32'h5A00F555, 32'h5AFFFFFF, 1'b1, 1'b0);
    trigCase("R7 near code", 32'h5A000554, 32'h5A000020, 1'b0, 1'b1);
    trigCase("R7 reset default", 32'h5A001000, 32'h5A000120, 1'b0, 1'b1);
    trigCase("R6 no trigger bit", 32'h5A000555, 32'h5A0000DF, 1'b0, 1'b0);

    // R7: code lives in status before trigger; a rejected status write does not count
    doWrite(7'd8, 32'h5A000555, po, sr);
    doWrite(7'd8, 32'h00000111, po, sr);
    doWrite(7'd7, 32'h5A000020, po, sr);
    check("R7 old status selects halt", {30'b0, po, sr}, 32'h2);

    // R9: read and write to same register in one cycle
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 7'd9; wrData = 32'h5A777777;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R9 read returns old value", rdData, mWdog);
    mWdog = 32'h00777777;
    doRead(7'd9, q);
    check("R9 new value next read", q, 32'h00777777);

    // R5: reset again restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mCtrl = 32'h102; mStat = 32'h1000; mWdog = 32'h0;
    for (int a = 7; a <= 9; a++) begin
      doRead(7'(a), q);
      check("R5 re-reset value", q, model(7'(a)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule